// File: doc/BRIEF.md
# Serial Flash Controller Stop-Entry Sequencer

This block decides when a serial flash interface controller may enter its low-power stop state. An external power manager raises a stop request. The sequencer moves into a waiting state and holds the acknowledge low. It raises the acknowledge only after the controller has fully drained: the flash engine is idle, no bus-side transfer is in flight, the receive buffer is empty, receive DMA is idle, and no interrupt-enabled status flag is pending. While stopped, the block drives both clock enables to zero. When the request is withdrawn, it returns to normal operation.

There are two independent clock-gating paths. The register-area enable follows a module-disable bit and the stop state. The memory-mapped-area enable follows the slave-bus enable and the stop state. Both enables come straight from flip-flops, so the clock-gating cell that uses them sees no combinational glitches. The slave-bus address, byte enables, write strobe and write data are forced to zero before they reach the memory-mapped logic unless the bus is open, which means the slave-bus enable is high and the block is not stopped. The flash protocol, the buffers and the DMA engine are outside this block and appear only as status inputs.

Top module: `lpstop_ctrl`

## Requirements
- R1: When reset is sampled low at a clock edge (synchronous, active low), the block returns to the running state. `stop_ack` is 0, `reg_clk_en` equals the inverse of `mod_dis`, and `mem_clk_en` is 1.
- R2: `stop_ack` rises at an edge only if, in the cycle before that edge, `stop_req` was 1 and all drain conditions held. A request raised at edge k enters the waiting state. The earliest edge at which the acknowledge can rise is therefore k+1.
- R3: Each of the following, on its own, keeps `stop_ack` at 0: `st_busy`=1, `st_bus_xfer`=1, `st_rx_fill`≠0, `st_rx_dma`=1.
- R4: A set bit in `st_flags` blocks the acknowledge only when the same bit of `st_irq_en` is 1. The blocking term is the OR-reduction of `st_flags & st_irq_en`.
- R5: If `stop_req` falls while the block is waiting, the block returns to running without ever raising `stop_ack`. A later request again needs two edges before it can be acknowledged.
- R6: Once acknowledged, `stop_ack` stays 1 while `stop_req` stays 1, whatever the status inputs do. It falls at the first edge at which `stop_req` is sampled 0.
- R7: `reg_clk_en` is registered. After each edge it equals (NOT `mod_dis`) AND (not stopped), with `mod_dis` taken as sampled at that edge.
- R8: `mem_clk_en` is registered. After each edge it equals `slv_en` AND (not stopped), with `slv_en` taken as sampled at that edge. It does not depend on `mod_dis`.
- R9: `mm_addr`, `mm_be`, `mm_wr` and `mm_wdata` equal their slave-bus inputs when `slv_en` is 1 and the block is not stopped. Otherwise they are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req | input | 1 | Stop request from the power manager |
| mod_dis | input | 1 | Module disable; gates the register-area clock |
| slv_en | input | 1 | Slave-bus module enable |
| st_busy | input | 1 | Flash engine busy status |
| st_bus_xfer | input | 1 | Bus-side transfer in progress |
| st_rx_fill | input | FILL_W | Receive buffer fill level |
| st_rx_dma | input | 1 | Receive DMA request active |
| st_flags | input | FLAG_W | Status flag vector |
| st_irq_en | input | FLAG_W | Interrupt enable per flag |
| slv_addr | input | ADDR_W | Slave-bus address |
| slv_be | input | BE_W | Slave-bus byte enables |
| slv_wr | input | 1 | Slave-bus write strobe (1 = write) |
| slv_wdata | input | DATA_W | Slave-bus write data |
| stop_ack | output | 1 | Stop acknowledge |
| reg_clk_en | output | 1 | Registered clock enable, register area |
| mem_clk_en | output | 1 | Registered clock enable, memory-mapped area |
| mm_addr | output | ADDR_W | Gated address to the memory-mapped logic |
| mm_be | output | BE_W | Gated byte enables |
| mm_wr | output | 1 | Gated write strobe |
| mm_wdata | output | DATA_W | Gated write data |

## Verification
The assertions check a set of rules on every cycle:
- an acknowledge never rises without a drain-complete cycle under an active request just before it;
- a low request always clears the acknowledge at the next edge;
- an acknowledge holds while the request persists;
- both clock enables are zero whenever the acknowledge is high;
- each enable tracks its sampled control input;
- the slave-bus outputs are zero whenever the bus is closed.

Only the bench's scenarios can show the following. Every one of the 32 blocker combinations and every flag/enable bit pairing gives the correct acknowledge decision. A withdrawn request really restarts the two-edge entry sequence. Status activity after the acknowledge is ignored.

// File: rtl/lpstop_pkg.sv
package lpstop_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_WAIT    = 2'd1,
    ST_STOPPED = 2'd2
  } lpstop_state_t;

  // Controller is drained when no blocker is active.
  function automatic logic is_drained(input logic busy,
                                      input logic xfer,
                                      input logic fill_nz,
                                      input logic dma,
                                      input logic irq_pend);
    return !(busy | xfer | fill_nz | dma | irq_pend);
  endfunction

  // Next state of the stop-entry sequencer.
  function automatic lpstop_state_t next_state(input lpstop_state_t cur,
                                               input logic req,
                                               input logic drained);
    lpstop_state_t n;
    n = cur;
    case (cur)
      ST_RUN:     if (req) n = ST_WAIT;
      ST_WAIT:    if (!req) n = ST_RUN; else if (drained) n = ST_STOPPED;
      ST_STOPPED: if (!req) n = ST_RUN;
      default:    n = ST_RUN;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/lpstop_drain.sv
module lpstop_drain #(
  parameter int FLAG_W = 8,
  parameter int FILL_W = 6
) (
  input  logic              busy,
  input  logic              xfer,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic              rx_dma,
  input  logic [FLAG_W-1:0] flags,
  input  logic [FLAG_W-1:0] irq_en,
  output logic              irq_pend,
  output logic              drained
);
  import lpstop_pkg::*;

  logic [FLAG_W-1:0] masked;

  genvar g;
  generate
    for (g = 0; g < FLAG_W; g++) begin : g_mask
      assign masked[g] = flags[g] & irq_en[g];
    end
  endgenerate

  assign irq_pend = |masked;
  assign drained  = is_drained(busy, xfer, |rx_fill, rx_dma, irq_pend);
endmodule

// File: rtl/lpstop_fsm.sv
module lpstop_fsm (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     drained,
  output lpstop_pkg::lpstop_state_t state,
  output logic                     nxt_stopped
);
  import lpstop_pkg::*;

  lpstop_state_t nxt;

  always_comb nxt = next_state(state, req, drained);
  assign nxt_stopped = (nxt == ST_STOPPED);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end
endmodule

// File: rtl/lpstop_gate.sv
module lpstop_gate #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_dis,
  input  logic              slv_en,
  input  logic              nxt_stopped,
  input  logic              stopped,
  input  logic [ADDR_W-1:0] slv_addr,
  input  logic [BE_W-1:0]   slv_be,
  input  logic              slv_wr,
  input  logic [DATA_W-1:0] slv_wdata,
  output logic              reg_clk_en,
  output logic              mem_clk_en,
  output logic [ADDR_W-1:0] mm_addr,
  output logic [BE_W-1:0]   mm_be,
  output logic              mm_wr,
  output logic [DATA_W-1:0] mm_wdata
);
  logic bus_open;

  // Enables come straight from flops so the clock gate sees clean levels.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_clk_en <= !mod_dis;
      mem_clk_en <= 1'b1;
    end else begin
      reg_clk_en <= !mod_dis && !nxt_stopped;
      mem_clk_en <= slv_en && !nxt_stopped;
    end
  end

  assign bus_open = slv_en && !stopped;
  assign mm_addr  = slv_addr  & {ADDR_W{bus_open}};
  assign mm_be    = slv_be    & {BE_W{bus_open}};
  assign mm_wr    = slv_wr    & bus_open;
  assign mm_wdata = slv_wdata & {DATA_W{bus_open}};
endmodule

// File: rtl/lpstop_ctrl.sv
module lpstop_ctrl #(
  parameter int FLAG_W = 8,
  parameter int FILL_W = 6,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_req,
  input  logic              mod_dis,
  input  logic              slv_en,
  input  logic              st_busy,
  input  logic              st_bus_xfer,
  input  logic [FILL_W-1:0] st_rx_fill,
  input  logic              st_rx_dma,
  input  logic [FLAG_W-1:0] st_flags,
  input  logic [FLAG_W-1:0] st_irq_en,
  input  logic [ADDR_W-1:0] slv_addr,
  input  logic [BE_W-1:0]   slv_be,
  input  logic              slv_wr,
  input  logic [DATA_W-1:0] slv_wdata,
  output logic              stop_ack,
  output logic              reg_clk_en,
  output logic              mem_clk_en,
  output logic [ADDR_W-1:0] mm_addr,
  output logic [BE_W-1:0]   mm_be,
  output logic              mm_wr,
  output logic [DATA_W-1:0] mm_wdata
);
  import lpstop_pkg::*;

  logic          drained_w;
  logic          irq_pend_w;
  logic          nxt_stopped_w;
  logic          stopped_w;
  lpstop_state_t state_w;

  lpstop_drain #(.FLAG_W(FLAG_W), .FILL_W(FILL_W)) u_drain (
    .busy(st_busy), .xfer(st_bus_xfer), .rx_fill(st_rx_fill),
    .rx_dma(st_rx_dma), .flags(st_flags), .irq_en(st_irq_en),
    .irq_pend(irq_pend_w), .drained(drained_w)
  );

  lpstop_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(stop_req), .drained(drained_w),
    .state(state_w), .nxt_stopped(nxt_stopped_w)
  );

  assign stopped_w = (state_w == ST_STOPPED);
  assign stop_ack  = stopped_w;

  lpstop_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .mod_dis(mod_dis), .slv_en(slv_en),
    .nxt_stopped(nxt_stopped_w), .stopped(stopped_w),
    .slv_addr(slv_addr), .slv_be(slv_be), .slv_wr(slv_wr),
    .slv_wdata(slv_wdata),
    .reg_clk_en(reg_clk_en), .mem_clk_en(mem_clk_en),
    .mm_addr(mm_addr), .mm_be(mm_be), .mm_wr(mm_wr), .mm_wdata(mm_wdata)
  );
endmodule

// File: rtl/lpstop_chk.sv
module lpstop_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_req,
  input logic              mod_dis,
  input logic              slv_en,
  input logic              drained_w,
  input logic              stop_ack,
  input logic              reg_clk_en,
  input logic              mem_clk_en,
  input logic [ADDR_W-1:0] mm_addr,
  input logic              mm_wr
);
  p_ack_after_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_ack) |-> $past(drained_w && stop_req));

  p_drop_clears_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_req |=> !stop_ack);

  p_ack_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ack && stop_req) |=> stop_ack);

  p_stop_gates_clocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ack |-> (!reg_clk_en && !mem_clk_en));

  p_reg_en_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_clk_en == (!$past(mod_dis) && !stop_ack));

  p_mem_en_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_ack && !$past(slv_en) |-> !mem_clk_en);

  p_bus_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!slv_en || stop_ack) |-> (mm_addr == '0 && !mm_wr));
endmodule

bind lpstop_ctrl lpstop_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .mod_dis(mod_dis),
  .slv_en(slv_en), .drained_w(drained_w), .stop_ack(stop_ack),
  .reg_clk_en(reg_clk_en), .mem_clk_en(mem_clk_en),
  .mm_addr(mm_addr), .mm_wr(mm_wr)
);

// File: tb/lpstop_ctrl_test.sv
module lpstop_ctrl_test;
  localparam int FLAG_W = 8;
  localparam int FILL_W = 6;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  logic clk = 1'b0;
  logic rst_n, stop_req, mod_dis, slv_en;
  logic st_busy, st_bus_xfer, st_rx_dma;
  logic [FILL_W-1:0] st_rx_fill;
  logic [FLAG_W-1:0] st_flags, st_irq_en;
  logic [ADDR_W-1:0] slv_addr;
  logic [BE_W-1:0]   slv_be;
  logic              slv_wr;
  logic [DATA_W-1:0] slv_wdata;
  logic stop_ack, reg_clk_en, mem_clk_en;
  logic [ADDR_W-1:0] mm_addr;
  logic [BE_W-1:0]   mm_be;
  logic              mm_wr;
  logic [DATA_W-1:0] mm_wdata;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lpstop_ctrl #(.FLAG_W(FLAG_W), .FILL_W(FILL_W), .ADDR_W(ADDR_W),
                .DATA_W(DATA_W)) uut (.*);

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic [63:0] act, input logic [63:0] exp,
                       input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_status();
    st_busy = 0; st_bus_xfer = 0; st_rx_fill = '0; st_rx_dma = 0;
    st_flags = '0; st_irq_en = '0;
  endtask

  // Request, wait two edges, compare the decision, then release.
  task automatic entry_trial(input logic expect_ack, input string tag);
    stop_req = 1;
    step();
    check(stop_ack, 0, {tag, " first edge R2"});
    step();
    check(stop_ack, expect_ack, tag);
    check(reg_clk_en, !expect_ack, {tag, " reg_clk_en R7"});
    check(mem_clk_en, !expect_ack, {tag, " mem_clk_en R8"});
    stop_req = 0;
    clear_status();
    step();
    check(stop_ack, 0, {tag, " release R6"});
    check(reg_clk_en, 1, {tag, " reg reopen R7"});
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0; stop_req = 0; mod_dis = 1; slv_en = 1;
    clear_status();
    slv_addr = '0; slv_be = '0; slv_wr = 0; slv_wdata = '0;
    step();
    // R1: reset with module disabled
    check(stop_ack, 0, "R1 ack in reset");
    check(reg_clk_en, 0, "R1 reg_clk_en with mod_dis");
    check(mem_clk_en, 1, "R1 mem_clk_en");
    mod_dis = 0;
    step();
    check(reg_clk_en, 1, "R1 reg_clk_en without mod_dis");
    rst_n = 1;
    step();

    // R2/R3: every blocker combination
    for (int c = 0; c < 32; c++) begin
      st_busy     = c[0];
      st_bus_xfer = c[1];
      st_rx_fill  = c[2] ? FILL_W'(c + 1) : '0;
      st_rx_dma   = c[3];
      st_flags    = c[4] ? 8'h10 : 8'h00;
      st_irq_en   = c[4] ? 8'h10 : 8'h00;
      entry_trial(c == 0, $sformatf("R3 blocker combo %0d", c));
    end

    // R4: flag/enable pairing
    for (int i = 0; i < FLAG_W; i++) begin
      for (int j = 0; j < FLAG_W; j++) begin
        st_flags  = FLAG_W'(1) << i;
        st_irq_en = FLAG_W'(1) << j;
        entry_trial(i != j, $sformatf("R4 flag %0d en %0d", i, j));
      end
    end

    // R5: withdrawal while waiting
    st_busy = 1; stop_req = 1;
    step(); step();
    check(stop_ack, 0, "R5 held off while busy");
    stop_req = 0; st_busy = 0;
    step();
    check(stop_ack, 0, "R5 withdrawn");
    step();
    check(stop_ack, 0, "R5 stays low");
    stop_req = 1;
    step();
    check(stop_ack, 0, "R5 restart needs two edges");
    step();
    check(stop_ack, 1, "R5 acknowledged after restart");

    // R6: hold regardless of status
    st_busy = 1; st_rx_dma = 1; st_flags = '1; st_irq_en = '1;
    for (int k = 0; k < 4; k++) begin
      step();
      check(stop_ack, 1, "R6 ack holds");
      check(reg_clk_en, 0, "R6 reg gated");
      check(mem_clk_en, 0, "R6 mem gated");
    end
    stop_req = 0; clear_status();
    step();
    check(stop_ack, 0, "R6 ack drops");
    check(mem_clk_en, 1, "R8 mem reopens");

    // R7/R8: independent enables
    mod_dis = 1;
    #1 check(reg_clk_en, 1, "R7 registered, not combinational");
    step();
    check(reg_clk_en, 0, "R7 mod_dis gates reg");
    check(mem_clk_en, 1, "R8 mod_dis leaves mem");
    mod_dis = 0; slv_en = 0;
    step();
    check(reg_clk_en, 1, "R7 reg reopens");
    check(mem_clk_en, 0, "R8 slv_en gates mem");
    slv_en = 1;
    step();
    check(mem_clk_en, 1, "R8 mem reopens");

    // R9: bus gating sweep
    for (int p = 0; p < 16; p++) begin
      slv_addr  = ADDR_W'(p * 273 + 5);
      slv_be    = BE_W'(p);
      slv_wr    = p[0];
      slv_wdata = DATA_W'(32'hA5C3_0000 + p * 4097);
      slv_en    = p[1];
      #1;
      check(mm_addr,  slv_en ? slv_addr  : '0, "R9 addr");
      check(mm_be,    slv_en ? slv_be    : '0, "R9 be");
      check(mm_wr,    slv_en ? slv_wr    : 1'b0, "R9 wr");
      check(mm_wdata, slv_en ? slv_wdata : '0, "R9 wdata");
    end
    slv_en = 1; stop_req = 1;
    step(); step();
    check(stop_ack, 1, "R9 stopped setup");
    check(mm_addr, 0, "R9 addr closed when stopped");
    check(mm_wdata, 0, "R9 wdata closed when stopped");
    stop_req = 0;
    step();
    check(mm_wdata, slv_wdata, "R9 reopened");

    summary();
  end
endmodule